// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Interface

This block is the digital front end of a 12-bit voltage-output converter that hangs on a parallel microcontroller bus. The bus master writes a word into an input register with an active-low chip select and a read/write strobe. It can read that word back over the shared data bus. A separate active-low load strobe then passes the input register into a DAC register, whose contents drive the converter code output. The codes are straight binary: 000h is zero scale and FFFh is full scale, at 1 mV per step and 4.095 V full scale.

The DAC register behaves as a latch. It is open for as long as the load strobe is low, whatever the chip select does, and it holds its value while the strobe is high. An asynchronous active-low clear forces the held code to zero and has priority over the load strobe. The input register is not touched by the clear. The bus is not an internal tri-state. The block gives out a data word and a per-bit output enable, and the pad ring merges them onto the shared bus.

All bus signals are sampled on the system clock. The input register takes a new word one clock edge after a write cycle is presented. While the load strobe is low, the code output follows the input register in that same cycle. The clear and load levels act on the code output combinationally.

Top module: `dacif_top`

## Requirements
- R1: After power-on reset the code output is 000h, the bus output enable is all zeros and the input register reads back as 000h.
- R2: At a clock edge with chip select low and read/write low (0 = write), the input register captures the data bus. At an edge with chip select high it keeps its value.
- R3: While chip select is low and read/write is high (1 = read), the output enable is all ones and the data output carries the input register. In every other case the output enable and the data output are all zeros.
- R4: While the load strobe is low and clear is high, the code output equals the input register, whatever chip select does.
- R5: While the load strobe is high and clear is high, the code output holds the input register value from the last clock edge at which the load strobe was low. Later writes do not change it.
- R6: With load strobe and chip select both low, each new bus word written reaches the code output one clock edge later. Once chip select is high, changes on the bus leave the code output unchanged.
- R7: While clear is low, the code output is 000h from the moment clear falls, even when the load strobe is low.
- R8: When clear is released with the load strobe high, the code output stays 000h until the load strobe is taken low.
- R9: When clear is released while the load strobe is low, the code output shows the input register contents at once, without waiting for a clock edge.
- R10: Clear does not alter the input register. A readback during or after a clear returns the last word written, and words written during a clear are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; bus signals are sampled on its rising edge |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cs_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| load_ni | input | 1 | Load strobe, active low; DAC register open while low |
| clr_ni | input | 1 | Asynchronous clear of the DAC register, active low |
| data_i | input | 12 | Data bus as seen from the pad |
| data_o | output | 12 | Readback data toward the pad |
| data_oe_o | output | 12 | Per-bit pad output enable, 1 = drive |
| code_o | output | 12 | Straight-binary code toward the converter |

## Verification
The hardest collisions are between a write and an open load strobe, and between the clear and the load strobe. In the first, a bus word enters the input register on the same edge at which the latch is open. In the second, clear falls or rises while the load strobe is already low. The bench sets up both by changing the load strobe, the chip select and the clear in the same half cycle as the bus word. It checks the code output twice per cycle: just after the inputs change, which checks the combinational clear and transparency, and just after the clock edge, which checks the captured values. A behavioural model is the judge. It keeps only the last written word and the last word that entered the latch.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int unsigned DefDataW = 12;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_mode_e;

  function automatic bus_mode_e decode_bus(input logic cs_n, input logic rw);
    if (cs_n) return BUS_IDLE;
    return rw ? BUS_READ : BUS_WRITE;
  endfunction
endpackage

// File: rtl/dacif_in_reg.sv
module dacif_in_reg
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_mode_e         mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] next_o,
  output logic [DATA_W-1:0] q_o
);
  always_comb begin
    next_o = q_o;
    if (mode_i == BUS_WRITE) next_o = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= next_o;
  end

  p_write_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BUS_WRITE) |=> (q_o == $past(data_i)));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != BUS_WRITE) |=> $stable(q_o));
endmodule

// File: rtl/dacif_dac_reg.sv
module dacif_dac_reg #(
  parameter int unsigned DATA_W = dacif_pkg::DefDataW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              clr_ni,
  input  logic [DATA_W-1:0] in_next_i,
  input  logic [DATA_W-1:0] in_q_i,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] held_q;

  // held_q tracks what the latch would hold if the strobe rose now
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)      held_q <= '0;
    else if (!clr_ni) held_q <= '0;
    else if (!load_ni) held_q <= in_next_i;
  end

  always_comb begin
    if (!clr_ni)       code_o = '0;
    else if (!load_ni) code_o = in_q_i;
    else               code_o = held_q;
  end

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (code_o == '0));

  p_closed_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && clr_ni && $past(load_ni) && $past(clr_ni)) |-> $stable(code_o));

  p_release_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && clr_ni && $past(load_ni) && !$past(clr_ni)) |-> (code_o == '0));

  p_open_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && clr_ni) |-> (code_o == in_q_i));
endmodule

// File: rtl/dacif_bus_drv.sv
module dacif_bus_drv
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_mode_e         mode_i,
  input  logic [DATA_W-1:0] q_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  logic rd_en;
  assign rd_en = (mode_i == BUS_READ);

  for (genvar b = 0; b < DATA_W; b++) begin : g_pad
    assign data_oe_o[b] = rd_en;
    assign data_o[b]    = rd_en & q_i[b];
  end

  p_oe_uniform_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) || (data_oe_o == '1));

  p_read_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0) |-> (data_o == q_i));

  p_release_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) |-> (data_o == '0));
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W = DefDataW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              load_ni,
  input  logic              clr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic [DATA_W-1:0] code_o
);
  bus_mode_e         mode;
  logic [DATA_W-1:0] in_next;
  logic [DATA_W-1:0] in_q;

  assign mode = decode_bus(cs_ni, rw_i);

  dacif_in_reg #(.DATA_W(DATA_W)) u_in_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .data_i (data_i),
    .next_o (in_next),
    .q_o    (in_q)
  );

  dacif_dac_reg #(.DATA_W(DATA_W)) u_dac_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_ni   (load_ni),
    .clr_ni    (clr_ni),
    .in_next_i (in_next),
    .in_q_i    (in_q),
    .code_o    (code_o)
  );

  dacif_bus_drv #(.DATA_W(DATA_W)) u_bus_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .q_i       (in_q),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  p_clear_keeps_input_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && cs_ni) |=> $stable(in_q));

  p_cs_high_code_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && clr_ni && !load_ni) |=> (!load_ni && clr_ni) -> $stable(code_o));
endmodule

// File: tb/dacif_top_tb_top.sv
`timescale 1ns/100ps
module dacif_top_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         rw = 1'b0;
  logic         load_n = 1'b1;
  logic         clr_n = 1'b1;
  logic [W-1:0] bus = '0;
  logic [W-1:0] dout;
  logic [W-1:0] doe;
  logic [W-1:0] code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_in;
  logic [W-1:0] m_dac;

  always #2.5 clk = ~clk;

  dacif_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw),
    .load_ni(load_n), .clr_ni(clr_n), .data_i(bus),
    .data_o(dout), .data_oe_o(doe), .code_o(code)
  );

  // behavioural model: last written word and last word into the latch
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in  = '0;
      m_dac = '0;
    end else begin
      if (!cs_n && !rw) m_in = bus;
      if (!clr_n)       m_dac = '0;
      else if (!load_n) m_dac = m_in;
    end
  end

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [W-1:0] e_code, e_oe, e_do;
    e_code = !clr_n ? '0 : (!load_n ? m_in : m_dac);
    e_oe   = (!cs_n && rw) ? '1 : '0;
    e_do   = (!cs_n && rw) ? m_in : '0;
    chk(tag, "code", code, e_code);
    chk(tag, "oe", doe, e_oe);
    chk(tag, "dout", dout, e_do);
  endtask

  // apply inputs after a falling edge, check then and after the next rising edge
  task automatic step(input string tag, input logic c, input logic r, input logic l,
                      input logic k, input logic [W-1:0] d);
    @(negedge clk);
    cs_n = c; rw = r; load_n = l; clr_n = k; bus = d;
    #1 compare(tag);
    @(posedge clk);
    #1 compare(tag);
  endtask

  task automatic expect_code(input string tag, input logic [W-1:0] exp);
    chk(tag, "code_abs", code, exp);
  endtask

  task automatic expect_read(input string tag, input logic [W-1:0] exp);
    chk(tag, "read_abs", dout, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 compare("R1");
    expect_code("R1", 12'h000);
    rst_n = 1'b1;
    step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 12'hABC);
    expect_read("R1", 12'h000);

    step("R2", 1'b0, 1'b0, 1'b1, 1'b1, 12'hA5C);
    step("R2", 1'b1, 1'b0, 1'b1, 1'b1, 12'h3C3);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b1, 12'h0F0);
    expect_read("R3", 12'hA5C);
    step("R3", 1'b1, 1'b1, 1'b1, 1'b1, 12'h0F0);
    step("R5", 1'b1, 1'b0, 1'b1, 1'b1, 12'h000);
    expect_code("R5", 12'h000);

    step("R4", 1'b1, 1'b0, 1'b0, 1'b1, 12'h111);
    expect_code("R4", 12'hA5C);
    step("R5", 1'b1, 1'b0, 1'b1, 1'b1, 12'h111);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 12'h123);
    expect_code("R5", 12'hA5C);
    step("R4", 1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
    expect_code("R4", 12'h123);

    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 12'h001);
    expect_code("R6", 12'h001);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 12'h800);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 12'hFFF);
    expect_code("R6", 12'hFFF);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 12'h555);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 12'hAAA);
    expect_code("R6", 12'hFFF);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 12'h7FE);
    expect_code("R5", 12'hFFF);

    step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    expect_code("R7", 12'h000);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
    step("R10", 1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
    expect_read("R10", 12'h7FE);
    step("R8", 1'b1, 1'b0, 1'b1, 1'b1, 12'h000);
    step("R8", 1'b1, 1'b0, 1'b1, 1'b1, 12'h000);
    expect_code("R8", 12'h000);
    step("R10", 1'b0, 1'b1, 1'b1, 1'b1, 12'h000);
    expect_read("R10", 12'h7FE);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
    expect_code("R8", 12'h7FE);

    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
    step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 12'h2D4);
    expect_code("R7", 12'h000);
    step("R10", 1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
    expect_read("R10", 12'h2D4);
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; load_n = 1'b0; clr_n = 1'b1;
    #1 compare("R9");
    expect_code("R9", 12'h2D4);
    @(posedge clk);
    #1 compare("R9");

    step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    @(negedge clk);
    load_n = 1'b0; clr_n = 1'b1;
    #1 compare("R9");
    expect_code("R9", 12'h2D4);
    @(posedge clk);
    #1 compare("R9");

    step("R3", 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule